// File: doc/BRIEF.md
# Elastic Channel Stage with Late VC Binding and Reply Escape

This block is one storage stage of a multidrop channel together with the two-class virtual-channel input of the router next to it. Flits move along the channel under valid/ready handshakes. No credits are reserved before a flit enters the channel. The stage keeps up to two flits, so the channel runs at one flit per cycle while the far end accepts every cycle.

The flit at the front of the stage takes one of three paths. A flit addressed to this node binds the router virtual channel of its own class when it reaches the front, and only there. Any other flit goes on to the next stage.

A reply (high class) that is bound elsewhere may be blocked because the next stage holds it off. If it waits at the front for a programmable number of cycles, and the local reply channel is unbound, the reply escapes into the local router. It is marked so that the router sends it on in the same direction and does not turn it.

On the router side, the two channels are read under strict priority, with replies first. Each channel is freed when the tail of its packet is read out. A blocked request can therefore never keep a reply out of this router.

Top module: `ebl_link_port`

## Requirements
- R1: While reset is asserted and right after it, up_ready is 1, dn_valid is 0 and rt_valid is 00.
- R2: The stage holds two flits. Flits for another node pass one per cycle on consecutive cycles with one cycle of latency. up_ready falls only in the cycle after a flit was accepted.
- R3: A flit whose dst field equals NODE_ID is written into the router channel selected by its hi bit. hi=1 selects the reply channel and is shown on rt_valid[1]. hi=0 selects the request channel and is shown on rt_valid[0]. The flit keeps its fields and its order within the class, and it is never offered downstream.
- R4: A head flit binds its class channel only while that channel is unbound. The binding holds until a flit with tail=1 is read from that channel. A local head whose channel is bound waits in the stage. A flit in a channel stays there until it is read.
- R5: When the reply channel is valid and rt_ready[1] is 1, the reply flit is read (rt_take=1, rt_hi=1). The request channel is read only when no reply is read in that cycle.
- R6: Flits for another node leave on dn_* unchanged and in arrival order. A request flit (hi=0) offered on dn_valid stays offered, with the same fields, until dn_ready accepts it.
- R7: Suppose a reply packet for another node has its first flit at the front of the stage, with dn_ready low, for esc_limit consecutive cycles, and the reply channel is unbound. The whole packet then enters the local reply channel.
- R8: Request packets never escape. A reply does not escape while the reply channel is bound; it stays offered downstream.
- R9: Every flit of an escaped packet leaves the router port with rt_esc=1. rt_esc=1 means the router must keep the flit in its direction of travel.
- R10: Every flit that enters is delivered exactly once, either downstream or at the router port.
- R11: The stage accepts flits with no regard to how full the router channels are, until both of its slots are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_limit | input | ESC_W | Stall cycles before a reply may escape |
| up_valid | input | 1 | Upstream flit valid |
| up_ready | output | 1 | Stage can take a flit |
| up_head | input | 1 | First flit of packet |
| up_tail | input | 1 | Last flit of packet |
| up_hi | input | 1 | Class: 1 reply, 0 request |
| up_esc | input | 1 | Escape marker carried in |
| up_dst | input | NODE_W | Target node index |
| up_data | input | DATA_W | Payload |
| dn_valid | output | 1 | Flit offered to next stage |
| dn_ready | input | 1 | Next stage accepts |
| dn_head | output | 1 | First flit of packet |
| dn_tail | output | 1 | Last flit of packet |
| dn_hi | output | 1 | Class |
| dn_esc | output | 1 | Escape marker |
| dn_dst | output | NODE_W | Target node index |
| dn_data | output | DATA_W | Payload |
| rt_ready | input | 2 | Router can read channel [1] reply, [0] request |
| rt_valid | output | 2 | Channel holds a flit, [1] reply, [0] request |
| rt_take | output | 1 | A flit is read this cycle |
| rt_hi | output | 1 | Class of the flit shown |
| rt_head | output | 1 | First flit of packet |
| rt_tail | output | 1 | Last flit of packet |
| rt_esc | output | 1 | Keep direction (escaped) |
| rt_dst | output | NODE_W | Target node index |
| rt_data | output | DATA_W | Payload |

## Verification
The bench fills the request channel, then sends a second local request. That request must wait in the stage, leave up_ready low and block a through flit behind it. A design that held a credit loop, or released the binding too early, would either drop up_ready at once or mix two packets in one channel.

Three cases around the escape are forced. In the first, a stalled reply must end up in the reply channel with its marker set. In the second, a stalled request must stay offered downstream. In the third, a reply must not escape while the reply channel is bound; a wrong escape rule would lose, misroute or duplicate flits that the scoreboard expects elsewhere.

Strict priority is tested with both channels full: replies must drain first. The random phase holds requests off at the router for long stretches while the downstream stall stays below the escape limit. Every flit must arrive unchanged and in order on its expected path.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
  parameter int NODE_W = 3;
  parameter int DATA_W = 16;

  typedef struct packed {
    logic              head;
    logic              tail;
    logic              hi;
    logic              esc;
    logic [NODE_W-1:0] dst;
    logic [DATA_W-1:0] data;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);

  typedef enum logic [1:0] {
    RT_IDLE  = 2'd0,
    RT_LOCAL = 2'd1,
    RT_PASS  = 2'd2,
    RT_ESC   = 2'd3
  } route_e;
endpackage

// File: rtl/ebl_flit_fifo.sv
module ebl_flit_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULLC);
  assign do_wr   = wr_en & ~full;
  assign do_rd   = rd_en & ~empty;
  assign rd_data = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == LAST) ? '0 : wp_q + PTR_W'(1);
    if (do_rd) rp_d = (rp_q == LAST) ? '0 : rp_q + PTR_W'(1);
    unique case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wr_data;
  end
endmodule

// File: rtl/ebl_steer.sv
module ebl_steer
  import ebl_pkg::*;
#(
  parameter int NODE_ID = 2,
  parameter int ESC_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_valid,
  input  flit_t            f_in,
  output logic             f_pop,
  output logic             dn_valid,
  input  logic             dn_ready,
  input  logic [1:0]       vc_free,
  input  logic [1:0]       vc_space,
  input  logic [ESC_W-1:0] esc_limit,
  output logic [1:0]       vc_wr,
  output flit_t            vc_wdata,
  output logic [1:0]       bind_set
);
  localparam logic [NODE_W-1:0] MY_NODE = NODE_W'(NODE_ID);

  route_e           route_q, route_d;
  logic             cls_q, cls_d;
  logic [ESC_W-1:0] stall_q, stall_d;
  logic             local_hit, stall_cond, esc_now;

  assign local_hit  = (f_in.dst == MY_NODE);
  assign stall_cond = (route_q == RT_IDLE) & f_valid & f_in.hi & ~local_hit & ~dn_ready;

  always_comb begin
    route_d  = route_q;
    cls_d    = cls_q;
    f_pop    = 1'b0;
    dn_valid = 1'b0;
    vc_wr    = 2'b00;
    bind_set = 2'b00;
    esc_now  = 1'b0;
    vc_wdata = f_in;
    unique case (route_q)
      RT_IDLE: begin
        if (f_valid && local_hit) begin
          if (vc_free[f_in.hi] && vc_space[f_in.hi]) begin
            vc_wr[f_in.hi]    = 1'b1;
            bind_set[f_in.hi] = 1'b1;
            f_pop             = 1'b1;
            cls_d             = f_in.hi;
            route_d           = f_in.tail ? RT_IDLE : RT_LOCAL;
          end
        end else if (f_valid) begin
          dn_valid = 1'b1;
          if (dn_ready) begin
            f_pop   = 1'b1;
            route_d = f_in.tail ? RT_IDLE : RT_PASS;
          end else if (f_in.hi && (stall_q >= esc_limit) && vc_free[1] && vc_space[1]) begin
            esc_now      = 1'b1;
            vc_wr[1]     = 1'b1;
            bind_set[1]  = 1'b1;
            vc_wdata.esc = 1'b1;
            f_pop        = 1'b1;
            route_d      = f_in.tail ? RT_IDLE : RT_ESC;
          end
        end
      end
      RT_LOCAL: begin
        if (f_valid && vc_space[cls_q]) begin
          vc_wr[cls_q] = 1'b1;
          f_pop        = 1'b1;
          if (f_in.tail) route_d = RT_IDLE;
        end
      end
      RT_PASS: begin
        dn_valid = f_valid;
        if (f_valid && dn_ready) begin
          f_pop = 1'b1;
          if (f_in.tail) route_d = RT_IDLE;
        end
      end
      RT_ESC: begin
        vc_wdata.esc = 1'b1;
        if (f_valid && vc_space[1]) begin
          vc_wr[1] = 1'b1;
          f_pop    = 1'b1;
          if (f_in.tail) route_d = RT_IDLE;
        end
      end
      default: route_d = RT_IDLE;
    endcase
  end

  always_comb begin
    stall_d = '0;
    if (stall_cond && !esc_now) stall_d = (stall_q == '1) ? stall_q : stall_q + ESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_IDLE;
      cls_q   <= 1'b0;
      stall_q <= '0;
    end else begin
      route_q <= route_d;
      cls_q   <= cls_d;
      stall_q <= stall_d;
    end
  end
endmodule

// File: rtl/ebl_vc_bank.sv
module ebl_vc_bank
  import ebl_pkg::*;
#(
  parameter int VC_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] vc_wr,
  input  flit_t      vc_wdata,
  input  logic [1:0] bind_set,
  output logic [1:0] vc_free,
  output logic [1:0] vc_space,
  input  logic [1:0] rt_ready,
  output logic [1:0] rt_valid,
  output logic       rt_take,
  output logic       rt_cls,
  output flit_t      rt_flit
);
  logic [1:0] bound_q, bound_d, rd_en, clr, empty, full;
  flit_t      head_f [2];
  logic       grant_hi, grant_lo;

  for (genvar c = 0; c < 2; c++) begin : g_vc
    ebl_flit_fifo #(.W(FLIT_W), .DEPTH(VC_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (vc_wr[c]),
      .wr_data (vc_wdata),
      .rd_en   (rd_en[c]),
      .rd_data (head_f[c]),
      .empty   (empty[c]),
      .full    (full[c])
    );
    assign rt_valid[c] = ~empty[c];
    assign vc_space[c] = ~full[c];
    assign vc_free[c]  = ~bound_q[c];
    assign clr[c]      = rd_en[c] & head_f[c].tail;
  end

  assign grant_hi = rt_valid[1] & rt_ready[1];
  assign grant_lo = ~grant_hi & rt_valid[0] & rt_ready[0];
  assign rd_en    = {grant_hi, grant_lo};
  assign rt_take  = grant_hi | grant_lo;
  assign rt_cls   = grant_hi | (~grant_lo & rt_valid[1]);
  assign rt_flit  = rt_cls ? head_f[1] : head_f[0];
  assign bound_d  = (bound_q | bind_set) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bound_q <= 2'b00;
    else        bound_q <= bound_d;
  end
endmodule

// File: rtl/ebl_link_port.sv
module ebl_link_port
  import ebl_pkg::*;
#(
  parameter int NODE_ID  = 2,
  parameter int ESC_W    = 4,
  parameter int EB_DEPTH = 2,
  parameter int VC_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ESC_W-1:0]  esc_limit,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_head,
  input  logic              up_tail,
  input  logic              up_hi,
  input  logic              up_esc,
  input  logic [NODE_W-1:0] up_dst,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_head,
  output logic              dn_tail,
  output logic              dn_hi,
  output logic              dn_esc,
  output logic [NODE_W-1:0] dn_dst,
  output logic [DATA_W-1:0] dn_data,
  input  logic [1:0]        rt_ready,
  output logic [1:0]        rt_valid,
  output logic              rt_take,
  output logic              rt_hi,
  output logic              rt_head,
  output logic              rt_tail,
  output logic              rt_esc,
  output logic [NODE_W-1:0] rt_dst,
  output logic [DATA_W-1:0] rt_data
);
  flit_t      up_f, front_f, vc_wdata, rt_f;
  logic       eb_empty, eb_full, f_pop;
  logic [1:0] vc_wr, bind_set, vc_free, vc_space;

  assign up_f     = '{head: up_head, tail: up_tail, hi: up_hi, esc: up_esc, dst: up_dst, data: up_data};
  assign up_ready = ~eb_full;

  ebl_flit_fifo #(.W(FLIT_W), .DEPTH(EB_DEPTH)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (up_valid),
    .wr_data (up_f),
    .rd_en   (f_pop),
    .rd_data (front_f),
    .empty   (eb_empty),
    .full    (eb_full)
  );

  ebl_steer #(.NODE_ID(NODE_ID), .ESC_W(ESC_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_valid   (~eb_empty),
    .f_in      (front_f),
    .f_pop     (f_pop),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .vc_free   (vc_free),
    .vc_space  (vc_space),
    .esc_limit (esc_limit),
    .vc_wr     (vc_wr),
    .vc_wdata  (vc_wdata),
    .bind_set  (bind_set)
  );

  ebl_vc_bank #(.VC_DEPTH(VC_DEPTH)) u_vcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .vc_wr    (vc_wr),
    .vc_wdata (vc_wdata),
    .bind_set (bind_set),
    .vc_free  (vc_free),
    .vc_space (vc_space),
    .rt_ready (rt_ready),
    .rt_valid (rt_valid),
    .rt_take  (rt_take),
    .rt_cls   (rt_hi),
    .rt_flit  (rt_f)
  );

  assign dn_head = front_f.head;
  assign dn_tail = front_f.tail;
  assign dn_hi   = front_f.hi;
  assign dn_esc  = front_f.esc;
  assign dn_dst  = front_f.dst;
  assign dn_data = front_f.data;
  assign rt_head = rt_f.head;
  assign rt_tail = rt_f.tail;
  assign rt_esc  = rt_f.esc;
  assign rt_dst  = rt_f.dst;
  assign rt_data = rt_f.data;
endmodule

// File: rtl/ebl_link_port_chk.sv
module ebl_link_port_chk
  import ebl_pkg::*;
#(
  parameter int NODE_ID = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_hi,
  input logic [NODE_W-1:0] dn_dst,
  input logic [DATA_W-1:0] dn_data,
  input logic [1:0]        rt_valid,
  input logic [1:0]        rt_ready,
  input logic              rt_take,
  input logic              rt_hi
);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ready) |-> $past(up_valid));

  p_not_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_dst != NODE_W'(NODE_ID)));

  p_lo_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid[0] && !(rt_take && !rt_hi) |=> rt_valid[0]);

  p_reply_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid[1] && rt_ready[1] |-> rt_take && rt_hi);

  p_req_offer_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready && !dn_hi |=> dn_valid && !dn_hi && $stable(dn_data) && $stable(dn_dst));
endmodule

bind ebl_link_port ebl_link_port_chk #(.NODE_ID(NODE_ID)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_ready (up_ready),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready),
  .dn_hi    (dn_hi),
  .dn_dst   (dn_dst),
  .dn_data  (dn_data),
  .rt_valid (rt_valid),
  .rt_ready (rt_ready),
  .rt_take  (rt_take),
  .rt_hi    (rt_hi)
);

// File: tb/ebl_link_port_test.sv
module ebl_link_port_test;
  import ebl_pkg::*;

  localparam int NODE_ID = 2;
  localparam int ESC_W   = 4;
  localparam logic [NODE_W-1:0] MY_NODE = NODE_W'(NODE_ID);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ESC_W-1:0]  esc_limit;
  logic              up_valid, up_ready, up_head, up_tail, up_hi, up_esc;
  logic [NODE_W-1:0] up_dst;
  logic [DATA_W-1:0] up_data;
  logic              dn_valid, dn_ready, dn_head, dn_tail, dn_hi, dn_esc;
  logic [NODE_W-1:0] dn_dst;
  logic [DATA_W-1:0] dn_data;
  logic [1:0]        rt_ready, rt_valid;
  logic              rt_take, rt_hi, rt_head, rt_tail, rt_esc;
  logic [NODE_W-1:0] rt_dst;
  logic [DATA_W-1:0] rt_data;

  always #5 clk = ~clk;

  ebl_link_port #(.NODE_ID(NODE_ID), .ESC_W(ESC_W)) uut (.*);

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    dn_xfers = 0;
  int    first_x = 0;
  int    last_x = 0;
  bit    done = 0;
  flit_t up_q[$];
  flit_t exp_dn[$];
  flit_t exp_lo[$];
  flit_t exp_hi[$];

  // knobs: dn_mode 0 random with capped low run, 1 held low, 2 held high
  int       dn_mode = 2;
  bit       rt_rand = 0;
  logic [1:0] rt_force = 2'b00;
  int       dn_low_run = 0;
  int       lo_block = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_pkt(input bit hi, input logic [NODE_W-1:0] dst, input int len, input bit esc_exp);
    for (int i = 0; i < len; i++) begin
      flit_t f;
      f.head = (i == 0);
      f.tail = (i == len - 1);
      f.hi   = hi;
      f.esc  = 1'b0;
      f.dst  = dst;
      f.data = DATA_W'($urandom);
      up_q.push_back(f);
      if (dst == MY_NODE) begin
        if (hi) exp_hi.push_back(f); else exp_lo.push_back(f);
      end else if (esc_exp) begin
        flit_t g = f;
        g.esc = 1'b1;
        exp_hi.push_back(g);
      end else exp_dn.push_back(f);
    end
  endtask

  function automatic logic [NODE_W-1:0] other_node();
    logic [NODE_W-1:0] r = NODE_W'($urandom);
    if (r == MY_NODE) r = r ^ NODE_W'(1);
    return r;
  endfunction

  task automatic cycle();
    @(negedge clk);
    cyc++;
    up_valid = (up_q.size() > 0);
    if (up_valid) begin
      up_head = up_q[0].head; up_tail = up_q[0].tail; up_hi = up_q[0].hi;
      up_esc = up_q[0].esc; up_dst = up_q[0].dst; up_data = up_q[0].data;
    end
    case (dn_mode)
      1: dn_ready = 1'b0;
      2: dn_ready = 1'b1;
      default: begin
        dn_ready = (dn_low_run >= 3) ? 1'b1 : (($urandom % 3) != 0);
        dn_low_run = dn_ready ? 0 : dn_low_run + 1;
      end
    endcase
    if (rt_rand) begin
      rt_ready[1] = (($urandom % 4) != 0);
      if (lo_block > 0) begin
        lo_block--;
        rt_ready[0] = 1'b0;
      end else if (($urandom % 40) == 0) begin
        lo_block = 10 + int'($urandom % 20);
        rt_ready[0] = 1'b0;
      end else rt_ready[0] = (($urandom % 2) != 0);
    end else rt_ready = rt_force;
    #1;
    if (up_valid && up_ready) void'(up_q.pop_front());
    if (dn_valid && dn_ready) begin
      flit_t a = '{head: dn_head, tail: dn_tail, hi: dn_hi, esc: dn_esc, dst: dn_dst, data: dn_data};
      if (dn_xfers == 0) first_x = cyc;
      last_x = cyc;
      dn_xfers++;
      if (exp_dn.size() == 0) chk(0, "R10", "unexpected downstream flit", 64'(a), 0);
      else begin
        flit_t e = exp_dn.pop_front();
        chk(a == e, "R6", "downstream flit", 64'(a), 64'(e));
      end
    end
    if (rt_take) begin
      flit_t a = '{head: rt_head, tail: rt_tail, hi: rt_hi, esc: rt_esc, dst: rt_dst, data: rt_data};
      if (rt_hi ? exp_hi.size() == 0 : exp_lo.size() == 0)
        chk(0, "R10", "unexpected router flit", 64'(a), 0);
      else begin
        flit_t e = rt_hi ? exp_hi.pop_front() : exp_lo.pop_front();
        chk(a == e, e.esc ? "R9" : "R3", "router flit", 64'(a), 64'(e));
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1a));
    rst_n = 1'b0; esc_limit = 4'd8; up_valid = 1'b0; up_head = 1'b0; up_tail = 1'b0;
    up_hi = 1'b0; up_esc = 1'b0; up_dst = '0; up_data = '0; dn_ready = 1'b0; rt_ready = 2'b00;
    repeat (3) @(negedge clk);
    chk(up_ready == 1'b1, "R1", "up_ready in reset", 64'(up_ready), 1);
    chk(dn_valid == 1'b0, "R1", "dn_valid in reset", 64'(dn_valid), 0);
    chk(rt_valid == 2'b00, "R1", "rt_valid in reset", 64'(rt_valid), 0);
    rst_n = 1'b1;
    run(1);
    chk(up_ready == 1'b1 && rt_valid == 2'b00, "R1", "outputs after release", 64'({up_ready, rt_valid}), 64'b100);

    // R2: back-to-back pass-through
    dn_mode = 2; rt_force = 2'b00; dn_xfers = 0;
    add_pkt(1'b0, other_node(), 4, 1'b0);
    run(8);
    chk(dn_xfers == 4 && (last_x - first_x) == 3, "R2", "consecutive transfer span",
        64'(last_x - first_x), 3);

    // R11, R4: request channel bound, second local request waits in stage
    add_pkt(1'b0, MY_NODE, 4, 1'b0);
    add_pkt(1'b0, MY_NODE, 2, 1'b0);
    add_pkt(1'b0, other_node(), 1, 1'b0);
    run(15);
    chk(up_ready == 1'b0, "R11", "stage full behind bound channel", 64'(up_ready), 0);
    chk(rt_valid == 2'b01, "R4", "only request channel holds flits", 64'(rt_valid), 1);
    chk(dn_valid == 1'b0, "R4", "through flit blocked behind waiting head", 64'(dn_valid), 0);
    rt_force = 2'b01;
    run(20);
    chk(rt_valid == 2'b00 && up_q.size() == 0, "R4", "bound packets drained", 64'(rt_valid), 0);

    // R7, R9: stalled reply escapes
    esc_limit = 4'd3; dn_mode = 1; rt_force = 2'b00;
    add_pkt(1'b1, other_node(), 3, 1'b1);
    run(12);
    chk(rt_valid == 2'b10, "R7", "escaped reply in reply channel", 64'(rt_valid), 2);
    chk(rt_esc == 1'b1, "R9", "escape marker shown", 64'(rt_esc), 1);
    chk(dn_valid == 1'b0, "R7", "nothing left offered downstream", 64'(dn_valid), 0);
    rt_force = 2'b10;
    run(8);

    // R8: request never escapes
    rt_force = 2'b00;
    add_pkt(1'b0, other_node(), 2, 1'b0);
    run(20);
    chk(dn_valid == 1'b1 && dn_hi == 1'b0, "R8", "stalled request still offered", 64'({dn_valid, dn_hi}), 2);
    chk(rt_valid == 2'b00, "R8", "request did not enter router", 64'(rt_valid), 0);
    dn_mode = 2;
    run(6);

    // R8: reply does not escape while reply channel is bound
    dn_mode = 1;
    add_pkt(1'b1, MY_NODE, 2, 1'b0);
    add_pkt(1'b1, other_node(), 2, 1'b0);
    run(20);
    chk(dn_valid == 1'b1 && dn_hi == 1'b1, "R8", "reply held while channel bound", 64'({dn_valid, dn_hi}), 3);
    chk(rt_valid == 2'b10, "R8", "reply channel holds only local packet", 64'(rt_valid), 2);
    dn_mode = 2; rt_force = 2'b11;
    run(10);

    // R5: strict priority with both channels filled
    rt_force = 2'b00;
    add_pkt(1'b0, MY_NODE, 3, 1'b0);
    add_pkt(1'b1, MY_NODE, 3, 1'b0);
    run(15);
    chk(rt_valid == 2'b11, "R5", "both channels filled", 64'(rt_valid), 3);
    rt_force = 2'b11;
    run(3);
    chk(rt_take && rt_hi, "R5", "third read still reply", 64'({rt_take, rt_hi}), 3);
    run(1);
    chk(rt_take && !rt_hi, "R5", "request read after replies", 64'({rt_take, rt_hi}), 2);
    run(5);

    // random mixed traffic with requests blocked at the router
    esc_limit = 4'd8; dn_mode = 0; rt_rand = 1;
    for (int p = 0; p < 150; p++) begin
      bit hi = $urandom % 2;
      logic [NODE_W-1:0] d = (($urandom % 5) < 2) ? MY_NODE : other_node();
      add_pkt(hi, d, 1 + int'($urandom % 4), 1'b0);
    end
    for (int i = 0; i < 20000 && up_q.size() > 0; i++) cycle();
    rt_rand = 0; rt_force = 2'b11; dn_mode = 2;
    for (int i = 0; i < 200 && (exp_dn.size() + exp_lo.size() + exp_hi.size()) > 0; i++) cycle();
    chk(up_q.size() == 0 && exp_dn.size() == 0 && exp_lo.size() == 0 && exp_hi.size() == 0,
        "R10", "all flits delivered", 64'(exp_dn.size() + exp_lo.size() + exp_hi.size()), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end
endmodule